// File: doc/BRIEF.md
# Interrupt and Wake-up Controller

This block collects the interrupt requests of a small processor core and turns them into one vector request at a time. It serves three sources: an edge on a dedicated external pin, an overflow pulse from a timer, and a change-of-level detector watching a six-pin port. It holds a flag bit and an enable bit per source, plus a global enable. It also tells a sleeping core when to wake, and whether it should then take the vector or go on with the instruction after the sleep.

Pin levels enter asynchronously and are synchronised inside the block. The change detector compares each watched pin against a reference that is reloaded whenever the core touches the port. The core writes the flag or enable register through a narrow write port and reads both back continuously. It signals return-from-interrupt and software-interrupt instructions with one-cycle strobes.

Top module: `intwake_ctrl`

## Requirements
- R1: After synchronous reset all flags, source enables and the global enable are 0, so `ien_rd_o` reads 8'h78 (bits 6:3 read as 1). `flag_rd_o`, `irq_o`, `cause_o` and `wake_o` are 0.
- R2: Bit positions in both registers: bit 0 external pin, bit 1 timer, bit 2 pin change, and bit 7 of the enable register is the global enable. External and timer flags are set by their events even when disabled. `flag_rd_o` returns the flags ANDed with their enables, with bits 7:3 at zero.
- R3: With `ext_sel_i`=1 the external flag is set on a rising edge of pin 0 when `edge_rise_i`=1, and on a falling edge when it is 0. The opposite edge has no effect.
- R4: The pin-change flag is set only while its enable is 1 and a watched pin differs from its reference. A pin is not watched if its change enable is 0, if its direction bit is 0 (output), or if it is pin 0 and `ext_sel_i`=1.
- R5: A `port_acc_i` strobe loads the synchronised pin levels as the new change reference.
- R6: When the global enable is set and any flag is set with its enable, the next cycle gives a one-cycle `irq_o` with `vec_o`=10'h008, and the global enable reads 0.
- R7: Only one source is named per request: `cause_o` is one-hot, with external first, then timer, then pin change.
- R8: `reti_i` sets the global enable. Flags stay set until a write of the flag register (`reg_sel_i`=0) loads them from `reg_wdata_i[2:0]`. An event in the same cycle as the write wins.
- R9: `swi_i` gives `irq_o` with `vec_o`=10'h002 and `cause_o`=0 in the next cycle, and leaves the global enable unchanged. A hardware request due in that cycle is issued one cycle later.
- R10: While `sleep_i`=1, a flag set with its enable raises `wake_o` in the next cycle whatever the global enable. A vector request follows only if the global enable is set.
- R11: A pin level change sampled at clock edge k sets its flag at edge k+2, through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 6 | Asynchronous port pin levels |
| chg_en_i | input | 6 | Per-pin change-detect enable |
| dir_in_i | input | 6 | Pin direction, 1 = input |
| ext_sel_i | input | 1 | Pin 0 serves as external interrupt input |
| edge_rise_i | input | 1 | External edge select, 1 = rising |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| port_acc_i | input | 1 | Port read or write strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 flag register, 1 enable register |
| reg_wdata_i | input | 4 | Bit 3 global enable (enable writes only), bits 2:0 per-source bits |
| reti_i | input | 1 | Return-from-interrupt strobe |
| swi_i | input | 1 | Software interrupt strobe |
| sleep_i | input | 1 | Core is in sleep |
| irq_o | output | 1 | Vector request, one cycle |
| vec_o | output | 10 | Vector address while `irq_o` is 1, else 0 |
| cause_o | output | 3 | One-hot source of a hardware request |
| flag_rd_o | output | 8 | Masked flag readback |
| ien_rd_o | output | 8 | Enable register readback |
| wake_o | output | 1 | Wake-up request |

## Verification
A timer pulse or a register write shows in the readback at the first falling edge after the capturing clock edge. A pin edge shows two edges later, and a vector request one edge after its flag and enables line up. Strobes for software interrupt and sleep produce `irq_o` or `wake_o` at the first edge. The bench drives every input just after a falling edge and samples there too. Its behavioural model keeps a delay line for the pin samples, so each output is compared in exactly the cycle it is due. The directed checks count those edges explicitly, for example the two-cycle gap of R11 and the one-cycle deferral of R9.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;
  localparam int SRC_CHG = 2;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/iwc_sync.sv
module iwc_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[g] <= 1'b0;
        stage2_q[g] <= 1'b0;
      end else begin
        stage1_q[g] <= async_i[g];
        stage2_q[g] <= stage1_q[g];
      end
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/iwc_edge.sv
module iwc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic sel_i,
  input  logic rise_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  always_comb begin
    if (!sel_i)      hit_o = 1'b0;
    else if (rise_i) hit_o = lvl_i & ~prev_q;
    else             hit_o = ~lvl_i & prev_q;
  end

  // R3: a reported edge means the level moved in the selected direction
  p_edge_dir_r3: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (lvl_i == rise_i) && ($past(lvl_i) != rise_i));
endmodule

// File: rtl/iwc_change.sv
module iwc_change #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic         acc_i,
  input  logic [W-1:0] chg_en_i,
  input  logic [W-1:0] dir_in_i,
  input  logic         ext_sel_i,
  output logic         hit_o
);
  logic [W-1:0] ref_q;
  logic [W-1:0] watch;

  always_ff @(posedge clk) begin
    if (rst)        ref_q <= '0;
    else if (acc_i) ref_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_watch
    if (g == 0) begin : g_shared
      assign watch[g] = chg_en_i[g] & dir_in_i[g] & ~ext_sel_i;
    end else begin : g_plain
      assign watch[g] = chg_en_i[g] & dir_in_i[g];
    end
  end

  assign hit_o = |((lvl_i ^ ref_q) & watch);

  // R5: a port access captures the synchronised levels as reference
  p_ref_load_r5: assert property (@(posedge clk) disable iff (rst)
    acc_i |=> ref_q == $past(lvl_i));
endmodule

// File: rtl/intwake_ctrl.sv
module intwake_ctrl
  import iwc_pkg::*;
#(
  parameter int          NPIN   = 6,
  parameter int          PC_W   = 10,
  parameter int          DATA_W = 8,
  parameter logic [PC_W-1:0] VEC_HW = 10'h008,
  parameter logic [PC_W-1:0] VEC_SW = 10'h002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [NPIN-1:0]   chg_en_i,
  input  logic [NPIN-1:0]   dir_in_i,
  input  logic              ext_sel_i,
  input  logic              edge_rise_i,
  input  logic              tmr_ovf_i,
  input  logic              port_acc_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [NSRC:0]     reg_wdata_i,
  input  logic              reti_i,
  input  logic              swi_i,
  input  logic              sleep_i,
  output logic              irq_o,
  output logic [PC_W-1:0]   vec_o,
  output logic [NSRC-1:0]   cause_o,
  output logic [DATA_W-1:0] flag_rd_o,
  output logic [DATA_W-1:0] ien_rd_o,
  output logic              wake_o
);
  localparam int PAD_W = DATA_W - 1 - NSRC;

  logic [NPIN-1:0] pin_s;
  logic            ext_hit;
  logic            chg_hit;
  src_vec_t        flag_q, ien_q, events, pend, pick;
  logic            gie_q;
  logic            take;
  logic            wr_flag, wr_ien;

  iwc_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(pin_s)
  );

  iwc_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(pin_s[0]), .sel_i(ext_sel_i),
    .rise_i(edge_rise_i), .hit_o(ext_hit)
  );

  iwc_change #(.W(NPIN)) u_chg (
    .clk(clk), .rst(rst), .lvl_i(pin_s), .acc_i(port_acc_i),
    .chg_en_i(chg_en_i), .dir_in_i(dir_in_i), .ext_sel_i(ext_sel_i),
    .hit_o(chg_hit)
  );

  assign wr_flag = reg_wr_i & ~reg_sel_i;
  assign wr_ien  = reg_wr_i &  reg_sel_i;

  always_comb begin
    events          = '0;
    events[SRC_EXT] = ext_hit;
    events[SRC_TMR] = tmr_ovf_i;
    events[SRC_CHG] = chg_hit & ien_q[SRC_CHG];
  end

  assign pend = flag_q & ien_q;
  assign pick = pend & (~pend + 1'b1);
  assign take = gie_q & (|pend) & ~swi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      ien_q   <= '0;
      gie_q   <= 1'b0;
      irq_o   <= 1'b0;
      vec_o   <= '0;
      cause_o <= '0;
      wake_o  <= 1'b0;
    end else begin
      flag_q <= (wr_flag ? reg_wdata_i[NSRC-1:0] : flag_q) | events;
      if (wr_ien) ien_q <= reg_wdata_i[NSRC-1:0];
      if (take)        gie_q <= 1'b0;
      else if (reti_i) gie_q <= 1'b1;
      else if (wr_ien) gie_q <= reg_wdata_i[NSRC];
      irq_o   <= take | swi_i;
      vec_o   <= swi_i ? VEC_SW : (take ? VEC_HW : '0);
      cause_o <= take ? pick : '0;
      wake_o  <= sleep_i & (|pend);
    end
  end

  assign flag_rd_o = {{(DATA_W-NSRC){1'b0}}, pend};
  assign ien_rd_o  = {gie_q, {PAD_W{1'b1}}, ien_q};

  // R7: at most one source per request
  p_one_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause_o));
  // R6: hardware requests use the hardware vector and drop the global enable
  p_hw_vec_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && cause_o != '0) |-> (vec_o == VEC_HW) && !gie_q);
  // R8: without a flag write no flag is lost
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R8: return-from-interrupt re-arms the global enable
  p_reti_r8: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !take) |=> gie_q);
  // R9: software interrupt always answered with its own vector
  p_swi_r9: assert property (@(posedge clk) disable iff (rst)
    swi_i |=> irq_o && (vec_o == VEC_SW) && (cause_o == '0));
  // R10: sleeping core woken by any enabled flag
  p_wake_r10: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && (|(flag_q & ien_q))) |=> wake_o);
endmodule

// File: tb/intwake_ctrl_tb_top.sv
module intwake_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] pin = '0, chg_en = '0, dir_in = 6'h3F;
  logic       ext_sel = 0, edge_rise = 1, tmr_ovf = 0, port_acc = 0;
  logic       reg_wr = 0, reg_sel = 0, reti = 0, swi = 0, sleep = 0;
  logic [3:0] wdata = '0;
  logic       irq_o, wake_o;
  logic [9:0] vec_o;
  logic [2:0] cause_o;
  logic [7:0] flag_rd_o, ien_rd_o;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  intwake_ctrl dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .chg_en_i(chg_en), .dir_in_i(dir_in),
    .ext_sel_i(ext_sel), .edge_rise_i(edge_rise), .tmr_ovf_i(tmr_ovf),
    .port_acc_i(port_acc), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(wdata), .reti_i(reti), .swi_i(swi), .sleep_i(sleep),
    .irq_o(irq_o), .vec_o(vec_o), .cause_o(cause_o), .flag_rd_o(flag_rd_o),
    .ien_rd_o(ien_rd_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, one step per rising edge
  logic [5:0] m_sq[3];          // delay line: first, second sample, previous
  logic [5:0] m_ref;
  logic [2:0] m_flag, m_en, m_cause;
  logic       m_gie, m_irq, m_wake;
  int         m_vec;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) m_sq[i] = '0;
      m_ref = '0; m_flag = '0; m_en = '0; m_gie = 0;
      m_irq = 0; m_vec = 0; m_cause = '0; m_wake = 0;
    end else begin
      logic [2:0] ev, pe, nf;
      logic       go, eh, ch;
      logic [5:0] w;
      eh = ext_sel && (edge_rise ? (m_sq[1][0] && !m_sq[2][0])
                                 : (!m_sq[1][0] && m_sq[2][0]));
      w = chg_en & dir_in;
      if (ext_sel) w[0] = 1'b0;
      ch = ((m_sq[1] ^ m_ref) & w) != 0;
      ev = {ch && m_en[2], tmr_ovf, eh};
      pe = m_flag & m_en;
      go = m_gie && pe != 0 && !swi;
      nf = ((reg_wr && !reg_sel) ? wdata[2:0] : m_flag) | ev;
      m_irq = go || swi;
      m_vec = swi ? 2 : (go ? 8 : 0);
      m_cause = '0;
      if (go) begin
        if (pe[0]) m_cause = 3'b001;
        else if (pe[1]) m_cause = 3'b010;
        else m_cause = 3'b100;
      end
      m_wake = sleep && pe != 0;
      if (go) m_gie = 0;
      else if (reti) m_gie = 1;
      else if (reg_wr && reg_sel) m_gie = wdata[3];
      if (reg_wr && reg_sel) m_en = wdata[2:0];
      m_flag = nf;
      if (port_acc) m_ref = m_sq[1];
      m_sq[2] = m_sq[1]; m_sq[1] = m_sq[0]; m_sq[0] = pin;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R2 flag readback", flag_rd_o, {5'b0, m_flag & m_en});
      chk("R6 enable readback", ien_rd_o, {m_gie, 4'hF, m_en});
      chk("R6 irq", irq_o, m_irq);
      chk("R6 vector", vec_o, m_vec);
      chk("R7 cause", cause_o, m_cause);
      chk("R10 wake", wake_o, m_wake);
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [3:0] d);
    reg_wr = 1; reg_sel = sel; wdata = d;
    step(1);
    reg_wr = 0;
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    chk("R1 enable reset", ien_rd_o, 8'h78);
    chk("R1 flag reset", flag_rd_o, 0);
    chk("R1 irq reset", irq_o, 0);
    chk("R1 wake reset", wake_o, 0);

    // external edge, flags set while disabled
    ext_sel = 1; pin[0] = 1; step(4);
    chk("R2 masked read", flag_rd_o, 0);
    wr_reg(1, 4'b0001);
    chk("R2 set while disabled", flag_rd_o, 1);
    wr_reg(0, 0);
    pin[0] = 0; step(4);
    chk("R3 falling ignored in rise mode", flag_rd_o, 0);
    edge_rise = 0; pin[0] = 1; step(4);
    chk("R3 rising ignored in fall mode", flag_rd_o, 0);
    pin[0] = 0; step(4);
    chk("R3 falling edge", flag_rd_o, 1);

    // timer and vectoring
    wr_reg(0, 0);
    wr_reg(1, 4'b0010);
    tmr_ovf = 1; step(1); tmr_ovf = 0;
    chk("R2 timer flag", flag_rd_o, 2);
    wr_reg(1, 4'b1010);
    chk("R6 not yet", irq_o, 0);
    step(1);
    chk("R6 irq", irq_o, 1);
    chk("R6 vector", vec_o, 8);
    chk("R7 timer cause", cause_o, 3'b010);
    chk("R6 global cleared", ien_rd_o, 8'h7A);
    step(1);
    chk("R6 single pulse", irq_o, 0);

    reti = 1; step(1); reti = 0;
    chk("R8 reti sets global", ien_rd_o, 8'hFA);
    chk("R8 flag kept", flag_rd_o, 2);
    step(1);
    chk("R8 retaken", irq_o, 1);
    wr_reg(0, 0);
    chk("R8 flag cleared by write", flag_rd_o, 0);
    tmr_ovf = 1; wr_reg(0, 0); tmr_ovf = 0;
    chk("R8 event beats write", flag_rd_o, 2);
    wr_reg(0, 0);

    // priority
    wr_reg(1, 4'b0011);
    pin[0] = 1; step(4);
    pin[0] = 0; tmr_ovf = 1; step(1); tmr_ovf = 0; step(3);
    chk("R7 both flags", flag_rd_o, 3);
    wr_reg(1, 4'b1011);
    step(1);
    chk("R7 external first", cause_o, 3'b001);
    wr_reg(0, 4'b0010);
    reti = 1; step(1); reti = 0;
    step(1);
    chk("R7 timer next", cause_o, 3'b010);
    wr_reg(0, 0);

    // software interrupt
    reti = 1; step(1); reti = 0;
    swi = 1; step(1); swi = 0;
    chk("R9 swi irq", irq_o, 1);
    chk("R9 swi vector", vec_o, 2);
    chk("R9 swi keeps global", ien_rd_o[7], 1);
    tmr_ovf = 1; step(1); tmr_ovf = 0;
    swi = 1; step(1); swi = 0;
    chk("R9 swi wins", vec_o, 2);
    step(1);
    chk("R9 deferred hw", vec_o, 8);
    chk("R9 deferred cause", cause_o, 3'b010);
    wr_reg(0, 0);

    // pin change
    ext_sel = 0;
    wr_reg(1, 4'b0000);
    chg_en = 6'h3F; dir_in = 6'h3F;
    port_acc = 1; step(1); port_acc = 0;
    pin[3] = 1; step(4);
    wr_reg(1, 4'b0100);
    chk("R4 needs enable", flag_rd_o, 0);
    step(1);
    chk("R4 change flag", flag_rd_o, 4);
    port_acc = 1; step(1); port_acc = 0;
    wr_reg(0, 0); step(2);
    chk("R5 reference reloaded", flag_rd_o, 0);
    dir_in[4] = 0; pin[4] = 1; step(4);
    chk("R4 output pin excluded", flag_rd_o, 0);
    chg_en[5] = 0; pin[5] = 1; step(4);
    chk("R4 disabled pin excluded", flag_rd_o, 0);
    ext_sel = 1; pin[0] = 1; step(4);
    chk("R4 external pin excluded", flag_rd_o, 0);
    pin[1] = 1; step(4);
    chk("R4 watched pin", flag_rd_o, 4);

    // sleep
    sleep = 1; step(1);
    chk("R10 wake without global", wake_o, 1);
    chk("R10 no vector", irq_o, 0);
    wr_reg(1, 4'b1100);
    step(1);
    chk("R10 vector with global", irq_o, 1);
    chk("R10 still waking", wake_o, 1);
    sleep = 0; step(1);
    chk("R10 wake drops", wake_o, 0);
    port_acc = 1; step(1); port_acc = 0;
    wr_reg(0, 0);

    // synchroniser latency
    edge_rise = 1;
    wr_reg(1, 4'b0001);
    pin[0] = 0; step(4);
    wr_reg(0, 0);
    pin[0] = 1; step(1);
    chk("R11 edge k", flag_rd_o, 0);
    step(1);
    chk("R11 edge k+1", flag_rd_o, 0);
    step(1);
    chk("R11 edge k+2", flag_rd_o, 1);

    step(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule